// File: doc/BRIEF.md
# Boundary-Splitting DMA Descriptor Builder

This block turns one disk transfer into a scatter-gather descriptor table for a bus-master DMA engine. A build begins with a start pulse that carries the total transfer length. The block then takes physical memory segments, each an address and a byte length, through a valid/ready handshake. For every segment it writes one or more descriptors into an external descriptor RAM through a simple write port. The engine behind this block cannot let one descriptor run across a 64 KiB address line. Any segment that crosses such a line is therefore cut at each line it meets, and every piece goes into its own table entry.

The table holds 64 entries. When all transfer bytes have been placed, the block pulses `done_o` and reports how many descriptors it wrote. Only the descriptor that finishes the transfer carries the end flag. If a 65th entry would be needed, the block stops the build and pulses `err_o` instead. After reset, and before it accepts any work, the block fills every table entry with a harmless terminator.

Top module: `dsb_builder`

## Requirements
- R1: After reset the block writes table indices 0 to 63 in order. Each of these entries has buffer address 0, byte count 1 and flags 0x8000. `busy_o` stays high and `seg_ready_o` stays low until the fill is finished.
- R2: A table word is 64 bits. Bits [31:0] hold the buffer address, bits [47:32] the byte count and bits [63:48] the flags, so the bytes are in little-endian order. The end flag is flags bit 15 (word bit 63). A byte count of 0 means 65536 bytes.
- R3: For every descriptor of a build, address[15:0] plus the byte count is at most 65536, so no descriptor crosses a 64 KiB line.
- R4: A segment that crosses one or more 64 KiB lines is cut at every line it crosses. The pieces come out in address order, are contiguous and add up to the segment.
- R5: Only the descriptor that brings the remaining transfer count to zero has flags 0x8000. Every earlier descriptor of the build has flags 0x0000.
- R6: Segment bytes beyond the remaining transfer length are not placed in the table. A segment whose usable length is zero is consumed without a write.
- R7: `done_o` pulses for one cycle, one cycle after the final write, with `desc_cnt_o` equal to the number of descriptors written. `done_o` and `err_o` never fire together.
- R8: When a build needs more than 64 descriptors, exactly 64 are written and then `err_o` pulses. No `done_o` follows, and the block returns to idle.
- R9: `start_i` is ignored while `busy_o` is high. `seg_ready_o` is high only while the block waits for a segment, and no table write happens in such a cycle.
- R10: The descriptors of each build go to consecutive table indices starting at 0.
- R11: A start with transfer length 0 gives a `done_o` pulse with `desc_cnt_o` equal to 0 and no table write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a build (accepted only when idle) |
| xfer_len_i | input | 18 | Total transfer length in bytes |
| busy_o | output | 1 | Fill or build in progress |
| seg_valid_i | input | 1 | Segment offered |
| seg_ready_o | output | 1 | Segment accepted this cycle when valid |
| seg_addr_i | input | 32 | Segment physical start address |
| seg_len_i | input | 18 | Segment length in bytes |
| tbl_we_o | output | 1 | Descriptor RAM write enable |
| tbl_addr_o | output | 6 | Descriptor RAM index |
| tbl_wdata_o | output | 64 | Descriptor word (layout in R2) |
| done_o | output | 1 | Build finished pulse |
| err_o | output | 1 | Table overflow pulse |
| desc_cnt_o | output | 7 | Descriptors written by the last finished build |

## Verification
The bench runs the builder on several kinds of segment input:
- A segment that lies inside one 64 KiB window checks that no cut is made where none is needed.
- A segment that crosses one line checks the cut position.
- A 128 KiB segment that starts mid-window crosses two lines. It shows that the splitting repeats, and it produces the count-0 encoding for a full 64 KiB piece.
- A two-segment transfer whose second segment is longer than the remaining length separates correct truncation from over-run. A stray start pulse during this build must leave the result unchanged.
- A build that needs exactly 64 entries and one that needs 128 sit on either side of the overflow limit.
- A zero-length start covers the empty build.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_SEG  = 2'd2,
    ST_CUT  = 2'd3
  } dsb_state_e;

endpackage

// File: rtl/dsb_piece_calc.sv
// Length of the next descriptor piece: the smaller of the bytes left in the
// segment and the distance to the next 2**CNT_W address line.
module dsb_piece_calc #(
  parameter int CNT_W = 16,
  parameter int LEN_W = 18
) (
  input  logic [CNT_W-1:0] addr_lo_i,
  input  logic [LEN_W-1:0] left_i,
  output logic [CNT_W:0]   piece_o
);

  localparam logic [CNT_W:0] SPAN = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W:0] to_line;

  always_comb begin
    to_line = SPAN - {1'b0, addr_lo_i};
    if (LEN_W'(to_line) > left_i) begin
      piece_o = left_i[CNT_W:0];
    end else begin
      piece_o = to_line;
    end
  end

endmodule

// File: rtl/dsb_desc_pack.sv
// Packs one descriptor: address low, count next, flags high (little-endian bytes).
module dsb_desc_pack #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  localparam int DESC_W = ADDR_W + 2 * CNT_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              last_i,
  output logic [DESC_W-1:0] word_o
);

  logic [CNT_W-1:0] flags;

  always_comb begin
    flags          = '0;
    flags[CNT_W-1] = last_i;
    word_o         = {flags, count_i, addr_i};
  end

endmodule

// File: rtl/dsb_builder.sv
module dsb_builder
  import dsb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 18,
  parameter int DEPTH  = 64,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int DESC_W = ADDR_W + 2 * CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  xfer_len_i,
  output logic              busy_o,
  input  logic              seg_valid_i,
  output logic              seg_ready_o,
  input  logic [ADDR_W-1:0] seg_addr_i,
  input  logic [LEN_W-1:0]  seg_len_i,
  output logic              tbl_we_o,
  output logic [IDX_W-1:0]  tbl_addr_o,
  output logic [DESC_W-1:0] tbl_wdata_o,
  output logic              done_o,
  output logic              err_o,
  output logic [IDX_W:0]    desc_cnt_o
);

  localparam logic [IDX_W:0] FULL     = (IDX_W+1)'(DEPTH);
  localparam logic [IDX_W:0] LAST_IDX = (IDX_W+1)'(DEPTH - 1);
  localparam logic [CNT_W:0] SPAN     = {1'b1, {CNT_W{1'b0}}};

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  dsb_state_e        state_q, state_n;
  logic [IDX_W:0]    idx_q, idx_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic [ADDR_W-1:0] cur_addr_q, cur_addr_n;
  logic [LEN_W-1:0]  cur_left_q, cur_left_n;
  logic [IDX_W:0]    cnt_q, cnt_n;
  logic              done_q, done_n;
  logic              err_q, err_n;

  logic [CNT_W:0]    piece;
  logic [LEN_W-1:0]  piece_ext;
  logic [LEN_W-1:0]  eff_len;
  logic              tbl_full, seg_end, xfer_end;
  logic [ADDR_W-1:0] pk_addr;
  logic [CNT_W-1:0]  pk_count;
  logic              pk_last;

  dsb_piece_calc #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_piece (
    .addr_lo_i (cur_addr_q[CNT_W-1:0]),
    .left_i    (cur_left_q),
    .piece_o   (piece)
  );

  assign piece_ext = LEN_W'(piece);
  assign eff_len   = (seg_len_i < rem_q) ? seg_len_i : rem_q;
  assign tbl_full  = (idx_q == FULL);
  assign seg_end   = (cur_left_q == piece_ext);
  assign xfer_end  = (rem_q == piece_ext);

  // terminator entry during the fill, live piece otherwise
  always_comb begin
    if (state_q == ST_INIT) begin
      pk_addr  = '0;
      pk_count = CNT_W'(1);
      pk_last  = 1'b1;
    end else begin
      pk_addr  = cur_addr_q;
      pk_count = piece[CNT_W-1:0];
      pk_last  = xfer_end;
    end
  end

  dsb_desc_pack #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_pack (
    .addr_i  (pk_addr),
    .count_i (pk_count),
    .last_i  (pk_last),
    .word_o  (tbl_wdata_o)
  );

  always_comb begin
    state_n    = state_q;
    idx_n      = idx_q;
    rem_n      = rem_q;
    cur_addr_n = cur_addr_q;
    cur_left_n = cur_left_q;
    cnt_n      = cnt_q;
    done_n     = 1'b0;
    err_n      = 1'b0;
    case (state_q)
      ST_INIT: begin
        idx_n = idx_q + 1'b1;
        if (idx_q == LAST_IDX) begin
          idx_n   = '0;
          state_n = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (start_i) begin
          idx_n = '0;
          if (xfer_len_i == '0) begin
            done_n = 1'b1;
            cnt_n  = '0;
          end else begin
            rem_n   = xfer_len_i;
            state_n = ST_SEG;
          end
        end
      end
      ST_SEG: begin
        if (seg_valid_i && (eff_len != '0)) begin
          cur_addr_n = seg_addr_i;
          cur_left_n = eff_len;
          state_n    = ST_CUT;
        end
      end
      ST_CUT: begin
        if (tbl_full) begin
          err_n   = 1'b1;
          state_n = ST_IDLE;
        end else begin
          idx_n      = idx_q + 1'b1;
          cur_addr_n = cur_addr_q + ADDR_W'(piece);
          cur_left_n = cur_left_q - piece_ext;
          rem_n      = rem_q - piece_ext;
          if (seg_end) begin
            if (xfer_end) begin
              done_n  = 1'b1;
              cnt_n   = idx_q + 1'b1;
              state_n = ST_IDLE;
            end else begin
              state_n = ST_SEG;
            end
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= ST_INIT;
      idx_q      <= '0;
      rem_q      <= '0;
      cur_addr_q <= '0;
      cur_left_q <= '0;
      cnt_q      <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q    <= state_n;
      idx_q      <= idx_n;
      rem_q      <= rem_n;
      cur_addr_q <= cur_addr_n;
      cur_left_q <= cur_left_n;
      cnt_q      <= cnt_n;
      done_q     <= done_n;
      err_q      <= err_n;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign seg_ready_o = (state_q == ST_SEG);
  assign tbl_we_o    = rst_sync_n &&
                       ((state_q == ST_INIT) || ((state_q == ST_CUT) && !tbl_full));
  assign tbl_addr_o  = idx_q[IDX_W-1:0];
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign desc_cnt_o  = cnt_q;

  // ---------------- assertions ----------------
  logic [CNT_W+1:0] chk_span_end;
  logic [CNT_W-1:0] chk_cnt;
  assign chk_cnt      = tbl_wdata_o[ADDR_W +: CNT_W];
  assign chk_span_end = {2'b00, tbl_wdata_o[CNT_W-1:0]} +
                        ((chk_cnt == '0) ? {1'b0, SPAN} : {2'b00, chk_cnt});

  p_init_fill_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_INIT) |-> (tbl_we_o && !seg_ready_o && busy_o));

  p_no_cross_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tbl_we_o && state_q == ST_CUT) |-> (chk_span_end <= {1'b0, SPAN}));

  p_end_then_done_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tbl_we_o && state_q == ST_CUT && tbl_wdata_o[DESC_W-1]) |=> done_o);

  p_done_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(done_o && err_o));

  p_err_after_full_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_o |-> ($past(idx_q) == FULL));

  p_ready_no_write_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seg_ready_o |-> !tbl_we_o);

endmodule

// File: tb/dsb_builder_tb.sv
module dsb_builder_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [17:0] xfer_len_i;
  logic        busy_o;
  logic        seg_valid_i;
  logic        seg_ready_o;
  logic [31:0] seg_addr_i;
  logic [17:0] seg_len_i;
  logic        tbl_we_o;
  logic [5:0]  tbl_addr_o;
  logic [63:0] tbl_wdata_o;
  logic        done_o;
  logic        err_o;
  logic [6:0]  desc_cnt_o;

  always #10 clk = ~clk;

  dsb_builder u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .xfer_len_i(xfer_len_i),
    .busy_o(busy_o), .seg_valid_i(seg_valid_i), .seg_ready_o(seg_ready_o),
    .seg_addr_i(seg_addr_i), .seg_len_i(seg_len_i), .tbl_we_o(tbl_we_o),
    .tbl_addr_o(tbl_addr_o), .tbl_wdata_o(tbl_wdata_o), .done_o(done_o),
    .err_o(err_o), .desc_cnt_o(desc_cnt_o)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  logic [63:0] expq[$];
  int          expa[$];
  longint      sa[$];
  longint      sl[$];
  string       req = "R1";
  bit          done_seen, err_seen, exp_err;
  int          got_cnt, exp_cnt;

  task automatic chk(input bit ok, input string r, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // reference model: behavioural cutting of the segment list
  task automatic build_expect(input longint xlen);
    longint rem, a, left, p, tb;
    int cnt;
    bit stop;
    rem = xlen; cnt = 0; stop = 0; exp_err = 0;
    foreach (sa[i]) begin
      if (stop || rem == 0) break;
      a = sa[i];
      left = (sl[i] < rem) ? sl[i] : rem;
      while (left > 0) begin
        tb = 65536 - (a & 64'hFFFF);
        p = (left < tb) ? left : tb;
        if (cnt == 64) begin exp_err = 1; stop = 1; break; end
        expq.push_back({((rem - p) == 0) ? 16'h8000 : 16'h0000,
                        16'(p & 64'hFFFF), 32'(a)});
        expa.push_back(cnt);
        a += p; left -= p; rem -= p; cnt++;
      end
    end
    exp_cnt = cnt;
  endtask

  // per-clock comparison of every table write and result pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (tbl_we_o) begin
        if (expq.size() == 0) begin
          chk(0, req, "unexpected write", longint'(tbl_wdata_o), 0);
        end else begin
          logic [63:0] e;
          int ea;
          e = expq.pop_front();
          ea = expa.pop_front();
          chk(tbl_wdata_o == e, req, "R2 descriptor word", longint'(tbl_wdata_o), longint'(e));
          chk(int'(tbl_addr_o) == ea, "R10", "table index", longint'(tbl_addr_o), ea);
          if (req != "R1") begin
            longint c;
            c = (tbl_wdata_o[47:32] == 0) ? 65536 : longint'(tbl_wdata_o[47:32]);
            chk((longint'(tbl_wdata_o[15:0]) + c) <= 65536, "R3", "line crossed",
                longint'(tbl_wdata_o[15:0]) + c, 65536);
          end
        end
      end
      if (done_o) begin done_seen = 1; got_cnt = int'(desc_cnt_o); end
      if (err_o) err_seen = 1;
    end
  end

  task automatic send_seg(input int i);
    if (done_seen || err_seen) return;
    seg_addr_i  = 32'(sa[i]);
    seg_len_i   = 18'(sl[i]);
    seg_valid_i = 1'b1;
    while (!seg_ready_o && !done_seen && !err_seen) @(negedge clk);
    if (seg_ready_o) @(negedge clk);
    seg_valid_i = 1'b0;
  endtask

  task automatic run_build(input string r, input longint xlen, input bit inject);
    req = r;
    build_expect(xlen);
    done_seen = 0; err_seen = 0; got_cnt = -1;
    @(negedge clk);
    start_i = 1'b1; xfer_len_i = 18'(xlen);
    @(negedge clk);
    start_i = 1'b0;
    foreach (sa[i]) begin
      send_seg(i);
      if (inject && i == 0) begin
        // R9: a start pulse mid-build must be ignored
        start_i = 1'b1; xfer_len_i = 18'd4;
        @(negedge clk);
        start_i = 1'b0;
      end
    end
    for (int k = 0; k < 5000 && !done_seen && !err_seen; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(err_seen == exp_err, exp_err ? "R8" : "R7", "error pulse", err_seen, exp_err);
    chk(done_seen == !exp_err, "R7", "done pulse", done_seen, !exp_err);
    if (done_seen) chk(got_cnt == exp_cnt, "R7", "descriptor count", got_cnt, exp_cnt);
    chk(expq.size() == 0, r, "missing writes", expq.size(), 0);
    chk(!busy_o, "R9", "idle after build", busy_o, 0);
    expq.delete(); expa.delete(); sa.delete(); sl.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; xfer_len_i = '0;
    seg_valid_i = 1'b0; seg_addr_i = '0; seg_len_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!seg_ready_o && !done_o && !err_o, "R1", "reset outputs",
        {seg_ready_o, done_o, err_o}, 0);
    for (int i = 0; i < 64; i++) begin
      expq.push_back({16'h8000, 16'h0001, 32'h0});
      expa.push_back(i);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o && !seg_ready_o, "R1", "busy during fill", {busy_o, seg_ready_o}, 2);
    for (int k = 0; k < 500 && busy_o; k++) @(negedge clk);
    chk(expq.size() == 0, "R1", "fill entries left", expq.size(), 0);
    chk(!seg_ready_o, "R9", "ready while idle", seg_ready_o, 0);
    expq.delete(); expa.delete();

    // R5: single segment inside one window
    sa.push_back(32'h0000_1000); sl.push_back(4096);
    run_build("R5", 4096, 0);

    // R4: one line crossed
    sa.push_back(32'h0001_F000); sl.push_back(32'h3000);
    run_build("R4", 32'h3000, 0);

    // R4: two lines crossed, middle piece has count 0 (R2)
    sa.push_back(32'h0000_8000); sl.push_back(32'h20000);
    run_build("R4", 32'h20000, 0);

    // R6: second segment truncated, with a stray start (R9)
    sa.push_back(32'h0000_0100); sl.push_back(32'h1000);
    sa.push_back(32'h0005_0000); sl.push_back(32'h4000);
    run_build("R6", 32'h3000, 1);

    // R6: zero-usable-length segment consumed without a write
    sa.push_back(32'h0000_2000); sl.push_back(0);
    sa.push_back(32'h0003_0000); sl.push_back(32'h200);
    run_build("R6", 32'h200, 0);

    // R10: exactly 64 descriptors (32 segments, each crossing one line)
    for (int i = 0; i < 32; i++) begin
      sa.push_back(longint'(i) * 32'h10000 + 32'h1FF00); sl.push_back(512);
    end
    run_build("R10", 32 * 512, 0);

    // R8: overflow, 128 pieces needed
    for (int i = 0; i < 128; i++) begin
      sa.push_back(longint'(i) * 32'h1000); sl.push_back(32'h400);
    end
    run_build("R8", 32'h20000, 0);

    // R11: empty build
    run_build("R11", 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule